// File: doc/BRIEF.md
# Shader Operand Fetch and Swizzle Unit

This block forms the three 4-component source operands of one decoded vertex-shader instruction. Each cycle it reads three 32-bit instruction words. For every source it extracts a 2-bit source-kind code, a 4-bit register index, an 8-bit swizzle and a sign-flip bit. It then picks a 128-bit vector from one of four places: the temporary file, the vertex input file, the constant port, or a zero vector. It reorders the lanes of that vector, optionally flips the sign of each lane, and registers the result for the ALU.

The unit holds the 12-entry temporary file and the 16-entry input file, and each has a simple write port. The temporary read view has a 13th entry, index 12, which returns the current position output vector `pos_vec` in place of stored data. Constant storage lives outside the block. The constant vector for the instruction arrives on `const_vec` in the same cycle as the instruction words.

Top module: `ofs_operand_fetch`

## Requirements
- R1: While `rst_n` is low, all three operand outputs are zero, and every temporary and input entry is cleared.
- R2: Source kind code 1 selects the temporary file. For source A, the register index is `instr_w2[31:28]` and the kind is `instr_w2[27:26]`. Indices 0..11 return the stored entry.
- R3: With kind 1, index 12 returns `pos_vec`. Indices 13..15 return a zero vector.
- R4: Kind code 2 selects input register 0..15 at the decoded index.
- R5: Kind code 3 returns `const_vec`.
- R6: Kind code 0 returns a zero vector (before the sign flip).
- R7: A vector holds lane X in bits 31:0, Y in 63:32, Z in 95:64 and W in 127:96. Each result lane has its own 2-bit code that names a source lane: 0=X, 1=Y, 2=Z, 3=W. For source A the codes are `instr_w1[7:6]` for result X, `[5:4]` for Y, `[3:2]` for Z and `[1:0]` for W.
- R8: When the sign-flip bit is set (source A: `instr_w1[8]`), bit 31 of each of the four lanes is inverted after the swizzle. No other bit changes.
- R9: Source B takes its sign flip from `instr_w2[25]`, its swizzle from `instr_w2[24:17]` (result X code highest), its index from `instr_w2[16:13]` and its kind from `instr_w2[12:11]`.
- R10: Source C takes its sign flip from `instr_w2[10]` and its swizzle from `instr_w2[9:2]`. Its index is `{instr_w2[1:0], instr_w3[31:30]}` and its kind is `instr_w3[29:28]`.
- R11: The outputs change only at a rising clock edge. They reflect the instruction, file contents and port vectors as they stood just before that edge.
- R12: A write to either file lands at the clock edge. A read in the same cycle returns the old contents. A temporary write to index 12..15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_w1 | input | 32 | Instruction word 1 |
| instr_w2 | input | 32 | Instruction word 2 |
| instr_w3 | input | 32 | Instruction word 3 |
| tmp_wr_en | input | 1 | Temporary file write enable |
| tmp_wr_idx | input | 4 | Temporary write index |
| tmp_wr_vec | input | 128 | Temporary write data |
| in_wr_en | input | 1 | Input file write enable |
| in_wr_idx | input | 4 | Input write index |
| in_wr_vec | input | 128 | Input write data |
| pos_vec | input | 128 | Current position output, seen as temporary 12 |
| const_vec | input | 128 | Constant vector for this instruction |
| opnd_a | output | 128 | Source A operand |
| opnd_b | output | 128 | Source B operand |
| opnd_c | output | 128 | Source C operand |

## Verification
Every operand result is due exactly one rising edge after the instruction words and port vectors are applied. A file write becomes visible to reads one edge after it is issued. The bench drives inputs on the falling edge and compares outputs on the following falling edge, so each sample sits after exactly one rising edge. Two extra checks guard the timing. One changes the instruction between edges and confirms the output holds. The other issues a write and a read of the same entry in one cycle and expects the old value first, then the new value one edge later.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_TMP  = 2'd1,
      SRC_IN   = 2'd2,
      SRC_CST  = 2'd3
   } src_kind_e;

   typedef struct packed {
      logic       neg;
      logic [7:0] swz;
      logic [3:0] idx;
      src_kind_e  kind;
   } src_field_t;

   function automatic src_field_t pick_src_a(input logic [31:0] w1, input logic [31:0] w2);
      src_field_t f;
      f.neg  = w1[8];
      f.swz  = w1[7:0];
      f.idx  = w2[31:28];
      f.kind = src_kind_e'(w2[27:26]);
      return f;
   endfunction

   function automatic src_field_t pick_src_b(input logic [31:0] w2);
      src_field_t f;
      f.neg  = w2[25];
      f.swz  = w2[24:17];
      f.idx  = w2[16:13];
      f.kind = src_kind_e'(w2[12:11]);
      return f;
   endfunction

   function automatic src_field_t pick_src_c(input logic [31:0] w2, input logic [31:0] w3);
      src_field_t f;
      f.neg  = w2[10];
      f.swz  = w2[9:2];
      f.idx  = {w2[1:0], w3[31:30]};
      f.kind = src_kind_e'(w3[29:28]);
      return f;
   endfunction

endpackage

// File: rtl/ofs_field_decode.sv
module ofs_field_decode
   import ofs_pkg::*;
(
   input  logic [31:0] instr_w1,
   input  logic [31:0] instr_w2,
   input  logic [31:0] instr_w3,
   output src_field_t  fld_a,
   output src_field_t  fld_b,
   output src_field_t  fld_c
);
   logic unused_bits;

   assign fld_a = pick_src_a(instr_w1, instr_w2);
   assign fld_b = pick_src_b(instr_w2);
   assign fld_c = pick_src_c(instr_w2, instr_w3);

   // opcode, constant index and destination fields belong to other stages
   assign unused_bits = ^{instr_w1[31:9], instr_w3[27:0]};
endmodule

// File: rtl/ofs_vec_file.sv
module ofs_vec_file #(
   parameter int DEPTH   = 12,
   parameter int VEC_W   = 128,
   parameter int AW      = 4,
   parameter int N_RD    = 3,
   parameter bit RST_CLR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_idx,
   input  logic [VEC_W-1:0]      wr_vec,
   input  logic [N_RD*AW-1:0]    rd_idx,
   output logic [N_RD*VEC_W-1:0] rd_vec
);
   localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1 || DEPTH > (1 << AW)) begin : g_bad_depth
      $error("ofs_vec_file: DEPTH does not fit the index width");
   end
   if (DW > AW) begin : g_bad_aw
      $error("ofs_vec_file: address width too small");
   end

   logic [VEC_W-1:0] mem [DEPTH];
   logic             wr_hit;

   assign wr_hit = wr_en && (32'(wr_idx) < DEPTH);

   if (RST_CLR) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (wr_hit) begin
            mem[wr_idx[DW-1:0]] <= wr_vec;
         end
      end
   end else begin : g_noclr
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (wr_hit) mem[wr_idx[DW-1:0]] <= wr_vec;
      end
   end

   for (genvar r = 0; r < N_RD; r++) begin : g_rd
      logic [AW-1:0] idx;
      assign idx = rd_idx[r*AW +: AW];
      assign rd_vec[r*VEC_W +: VEC_W] = (32'(idx) < DEPTH) ? mem[idx[DW-1:0]] : '0;
   end
endmodule

// File: rtl/ofs_operand_path.sv
module ofs_operand_path
   import ofs_pkg::*;
#(
   parameter int COMP_W = 32,
   parameter int N_COMP = 4,
   parameter int N_TMP  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  src_field_t               fld,
   input  logic [COMP_W*N_COMP-1:0] tmp_vec,
   input  logic [COMP_W*N_COMP-1:0] in_vec,
   input  logic [COMP_W*N_COMP-1:0] pos_vec,
   input  logic [COMP_W*N_COMP-1:0] const_vec,
   output logic [COMP_W*N_COMP-1:0] opnd
);
   localparam int VEC_W = COMP_W * N_COMP;

   logic [VEC_W-1:0] tmp_view;
   logic [VEC_W-1:0] picked;
   logic [VEC_W-1:0] shaped;

   // temporary view: stored entries, then the position alias, then holes
   always_comb begin
      if (32'(fld.idx) < N_TMP)       tmp_view = tmp_vec;
      else if (32'(fld.idx) == N_TMP) tmp_view = pos_vec;
      else                            tmp_view = '0;
   end

   always_comb begin
      case (fld.kind)
         SRC_TMP: picked = tmp_view;
         SRC_IN:  picked = in_vec;
         SRC_CST: picked = const_vec;
         default: picked = '0;
      endcase
   end

   for (genvar c = 0; c < N_COMP; c++) begin : g_lane
      logic [1:0]        code;
      logic [COMP_W-1:0] lane;
      assign code = fld.swz[(N_COMP-1-c)*2 +: 2];
      assign lane = picked[32'(code)*COMP_W +: COMP_W];
      assign shaped[c*COMP_W +: COMP_W] = {lane[COMP_W-1] ^ fld.neg, lane[COMP_W-2:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) opnd <= '0;
      else        opnd <= shaped;
   end
endmodule

// File: rtl/ofs_operand_fetch.sv
module ofs_operand_fetch
   import ofs_pkg::*;
#(
   parameter int COMP_W    = 32,
   parameter int N_COMP    = 4,
   parameter int N_TMP     = 12,
   parameter int N_IN      = 16,
   parameter bit FILES_CLR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [31:0]              instr_w1,
   input  logic [31:0]              instr_w2,
   input  logic [31:0]              instr_w3,
   input  logic                     tmp_wr_en,
   input  logic [3:0]               tmp_wr_idx,
   input  logic [COMP_W*N_COMP-1:0] tmp_wr_vec,
   input  logic                     in_wr_en,
   input  logic [3:0]               in_wr_idx,
   input  logic [COMP_W*N_COMP-1:0] in_wr_vec,
   input  logic [COMP_W*N_COMP-1:0] pos_vec,
   input  logic [COMP_W*N_COMP-1:0] const_vec,
   output logic [COMP_W*N_COMP-1:0] opnd_a,
   output logic [COMP_W*N_COMP-1:0] opnd_b,
   output logic [COMP_W*N_COMP-1:0] opnd_c
);
   localparam int VEC_W = COMP_W * N_COMP;
   localparam int IDX_W = 4;
   localparam int N_SRC = 3;

   if (N_COMP != 4) begin : g_bad_comp
      $error("ofs_operand_fetch: swizzle encoding needs four lanes");
   end
   if (COMP_W < 2) begin : g_bad_cw
      $error("ofs_operand_fetch: lane too narrow for a sign bit");
   end
   if (N_TMP + 1 > (1 << IDX_W)) begin : g_bad_tmp
      $error("ofs_operand_fetch: temporaries plus alias exceed index range");
   end
   if (N_IN > (1 << IDX_W)) begin : g_bad_in
      $error("ofs_operand_fetch: input file exceeds index range");
   end

   src_field_t                fld [N_SRC];
   logic [N_SRC*IDX_W-1:0]    rd_idx;
   logic [N_SRC*VEC_W-1:0]    tmp_rd;
   logic [N_SRC*VEC_W-1:0]    in_rd;
   logic [VEC_W-1:0]          opnd [N_SRC];

   ofs_field_decode u_dec (
      .instr_w1 (instr_w1),
      .instr_w2 (instr_w2),
      .instr_w3 (instr_w3),
      .fld_a    (fld[0]),
      .fld_b    (fld[1]),
      .fld_c    (fld[2])
   );

   for (genvar s = 0; s < N_SRC; s++) begin : g_idx
      assign rd_idx[s*IDX_W +: IDX_W] = fld[s].idx;
   end

   ofs_vec_file #(
      .DEPTH(N_TMP), .VEC_W(VEC_W), .AW(IDX_W), .N_RD(N_SRC), .RST_CLR(FILES_CLR)
   ) u_tmp_file (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tmp_wr_en),
      .wr_idx (tmp_wr_idx),
      .wr_vec (tmp_wr_vec),
      .rd_idx (rd_idx),
      .rd_vec (tmp_rd)
   );

   ofs_vec_file #(
      .DEPTH(N_IN), .VEC_W(VEC_W), .AW(IDX_W), .N_RD(N_SRC), .RST_CLR(FILES_CLR)
   ) u_in_file (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (in_wr_en),
      .wr_idx (in_wr_idx),
      .wr_vec (in_wr_vec),
      .rd_idx (rd_idx),
      .rd_vec (in_rd)
   );

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      ofs_operand_path #(
         .COMP_W(COMP_W), .N_COMP(N_COMP), .N_TMP(N_TMP)
      ) u_path (
         .clk       (clk),
         .rst_n     (rst_n),
         .fld       (fld[s]),
         .tmp_vec   (tmp_rd[s*VEC_W +: VEC_W]),
         .in_vec    (in_rd[s*VEC_W +: VEC_W]),
         .pos_vec   (pos_vec),
         .const_vec (const_vec),
         .opnd      (opnd[s])
      );
   end

   assign opnd_a = opnd[0];
   assign opnd_b = opnd[1];
   assign opnd_c = opnd[2];
endmodule

// File: rtl/ofs_operand_fetch_chk.sv
module ofs_operand_fetch_chk #(
   parameter int COMP_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [31:0]           instr_w1,
   input logic [31:0]           instr_w2,
   input logic [31:0]           instr_w3,
   input logic [4*COMP_W-1:0]   pos_vec,
   input logic [4*COMP_W-1:0]   const_vec,
   input logic [4*COMP_W-1:0]   opnd_a,
   input logic [4*COMP_W-1:0]   opnd_b,
   input logic [4*COMP_W-1:0]   opnd_c
);
   localparam logic [7:0] SWZ_ID = 8'h1B;

   logic [1:0] ka, kc;
   logic [3:0] ia;
   logic [7:0] sa, sc;
   logic       na, nc;
   logic       unused_chk;

   assign ka = instr_w2[27:26];
   assign ia = instr_w2[31:28];
   assign sa = instr_w1[7:0];
   assign na = instr_w1[8];
   assign kc = instr_w3[29:28];
   assign sc = instr_w2[9:2];
   assign nc = instr_w2[10];
   assign unused_chk = ^{instr_w1[31:9], instr_w3[31:30], instr_w3[27:0], opnd_b};

   assert_zero_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ka == 2'd0 && !na) |=> (opnd_a == '0));

   assert_const_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ka == 2'd3 && sa == SWZ_ID && !na) |=> (opnd_a == $past(const_vec)));

   assert_pos_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ka == 2'd1 && ia == 4'd12 && sa == SWZ_ID && !na) |=> (opnd_a == $past(pos_vec)));

   assert_hole_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ka == 2'd1 && ia > 4'd12 && !na) |=> (opnd_a == '0));

   assert_broadcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ka == 2'd3 && sa == 8'h00 && !na) |=> (opnd_a == {4{$past(const_vec[COMP_W-1:0])}}));

   assert_sign_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ka == 2'd3 && sa == SWZ_ID && na) |=>
      ((opnd_a ^ $past(const_vec)) == {4{1'b1, {(COMP_W-1){1'b0}}}}));

   assert_src_c_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (kc == 2'd3 && sc == SWZ_ID && !nc) |=> (opnd_c == $past(const_vec)));
endmodule

bind ofs_operand_fetch ofs_operand_fetch_chk #(.COMP_W(COMP_W)) u_ofs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .instr_w1  (instr_w1),
   .instr_w2  (instr_w2),
   .instr_w3  (instr_w3),
   .pos_vec   (pos_vec),
   .const_vec (const_vec),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .opnd_c    (opnd_c)
);

// File: tb/test_ofs_operand_fetch.sv
`timescale 1ns/1ps
module test_ofs_operand_fetch;
   localparam int CW = 32;
   localparam int VW = 128;
   localparam int NT = 12;
   localparam int NI = 16;
   localparam logic [7:0] SWZ_ID = 8'h1B;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [31:0]   instr_w1 = '0, instr_w2 = '0, instr_w3 = '0;
   logic          tmp_wr_en = 1'b0, in_wr_en = 1'b0;
   logic [3:0]    tmp_wr_idx = '0, in_wr_idx = '0;
   logic [VW-1:0] tmp_wr_vec = '0, in_wr_vec = '0, pos_vec = '0, const_vec = '0;
   logic [VW-1:0] opnd_a, opnd_b, opnd_c;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [VW-1:0] tmod [NT];
   logic [VW-1:0] imod [NI];
   logic [VW-1:0] ea, eb, ec;

   always #2.5 clk = ~clk;

   ofs_operand_fetch i_ofs_operand_fetch (
      .clk(clk), .rst_n(rst_n),
      .instr_w1(instr_w1), .instr_w2(instr_w2), .instr_w3(instr_w3),
      .tmp_wr_en(tmp_wr_en), .tmp_wr_idx(tmp_wr_idx), .tmp_wr_vec(tmp_wr_vec),
      .in_wr_en(in_wr_en), .in_wr_idx(in_wr_idx), .in_wr_vec(in_wr_vec),
      .pos_vec(pos_vec), .const_vec(const_vec),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c)
   );

   function automatic logic [VW-1:0] mkvec(input logic [7:0] tag, input logic [7:0] ent);
      logic [VW-1:0] v;
      for (int c = 0; c < 4; c++) v[c*CW +: CW] = {tag, ent, 8'h5A, 8'(c + 1)};
      return v;
   endfunction

   // expected source vector per R2..R6
   function automatic logic [VW-1:0] fetch(input logic [1:0] k, input logic [3:0] r);
      case (k)
         2'd1: begin
            if (r < 4'd12)       return tmod[r];
            else if (r == 4'd12) return pos_vec;
            else                 return '0;
         end
         2'd2: return imod[r];
         2'd3: return const_vec;
         default: return '0;
      endcase
   endfunction

   // lane reorder and sign flip per R7, R8
   function automatic logic [VW-1:0] shape(input logic [VW-1:0] v, input logic [7:0] s, input logic n);
      logic [VW-1:0] o;
      for (int c = 0; c < 4; c++) begin
         logic [1:0]    code;
         logic [CW-1:0] lane;
         code = s[(3-c)*2 +: 2];
         lane = v[int'(code)*CW +: CW];
         lane[CW-1] = lane[CW-1] ^ n;
         o[c*CW +: CW] = lane;
      end
      return o;
   endfunction

   task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s got %h want %h", req, act, exp);
      end
   endtask

   task automatic set_ops(
      input logic [1:0] ka, input logic [3:0] ra, input logic [7:0] sa, input logic na,
      input logic [1:0] kb, input logic [3:0] rb, input logic [7:0] sb, input logic nb,
      input logic [1:0] kc, input logic [3:0] rc, input logic [7:0] sc, input logic nc);
      instr_w1 = {23'h2B5A3C, na, sa};
      instr_w2 = {ra, ka, nb, sb, rb, kb, nc, sc, rc[3:2]};
      instr_w3 = {rc[1:0], kc, 28'h9C3E5A1};
      ea = shape(fetch(ka, ra), sa, na);
      eb = shape(fetch(kb, rb), sb, nb);
      ec = shape(fetch(kc, rc), sc, nc);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R11 watchdog expired got hang want completion");
         summary();
         $finish;
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset opnd_a", opnd_a, '0);
      check("R1 reset opnd_b", opnd_b, '0);
      check("R1 reset opnd_c", opnd_c, '0);
      rst_n = 1'b1;
      pos_vec   = mkvec(8'h33, 8'h0C);
      const_vec = mkvec(8'hC4, 8'hEE);
      step();

      // R1: files read back cleared right after reset
      set_ops(2'd1, 4'd5, SWZ_ID, 1'b0, 2'd2, 4'd9, SWZ_ID, 1'b0, 2'd2, 4'd15, SWZ_ID, 1'b0);
      ea = '0; eb = '0; ec = '0;
      step();
      check("R1 cleared tmp", opnd_a, ea);
      check("R1 cleared input", opnd_b, eb);
      check("R1 cleared input 15", opnd_c, ec);

      // fill the files
      for (int i = 0; i < NT; i++) begin
         tmp_wr_en = 1'b1; tmp_wr_idx = 4'(i); tmp_wr_vec = mkvec(8'h11, 8'(i));
         tmod[i] = mkvec(8'h11, 8'(i));
         step();
      end
      for (int i = 12; i < 16; i++) begin   // R12: ignored writes
         tmp_wr_en = 1'b1; tmp_wr_idx = 4'(i); tmp_wr_vec = {4{32'hDEADBEEF}};
         step();
      end
      tmp_wr_en = 1'b0;
      for (int i = 0; i < NI; i++) begin
         in_wr_en = 1'b1; in_wr_idx = 4'(i); in_wr_vec = mkvec(8'h22, 8'(i));
         imod[i] = mkvec(8'h22, 8'(i));
         step();
      end
      in_wr_en = 1'b0;

      // sweep kinds, indices and sign flips across all three sources
      for (int k = 0; k < 4; k++) begin
         for (int r = 0; r < 16; r++) begin
            for (int n = 0; n < 2; n++) begin
               string tag;
               case (k)
                  0: tag = "R6";
                  1: tag = (r >= 12) ? "R3 R12" : "R2";
                  2: tag = "R4";
                  default: tag = "R5";
               endcase
               set_ops(2'(k), 4'(r), SWZ_ID, 1'(n),
                       2'(k), 4'((r + 5) % 16), 8'hE4, 1'(n ^ 1),
                       2'(k), 4'((r + 9) % 16), 8'h6C, 1'(n));
               step();
               check($sformatf("%s src A k%0d r%0d", tag, k, r), opnd_a, ea);
               check($sformatf("R9 src B k%0d r%0d", k, (r + 5) % 16), opnd_b, eb);
               check($sformatf("R10 src C k%0d r%0d", k, (r + 9) % 16), opnd_c, ec);
            end
         end
      end

      // every swizzle code with and without sign flip
      for (int s = 0; s < 256; s++) begin
         for (int n = 0; n < 2; n++) begin
            set_ops(2'd3, 4'd0, 8'(s), 1'(n),
                    2'd2, 4'd7, 8'(255 - s), 1'(n),
                    2'd1, 4'd4, 8'(s), 1'(n ^ 1));
            step();
            check($sformatf("R7 R8 src A swz %02h", s), opnd_a, ea);
            check($sformatf("R9 R8 src B swz %02h", 255 - s), opnd_b, eb);
            check($sformatf("R10 R8 src C swz %02h", s), opnd_c, ec);
         end
      end

      // R11: output holds between edges
      set_ops(2'd2, 4'd3, SWZ_ID, 1'b0, 2'd3, 4'd0, SWZ_ID, 1'b1, 2'd1, 4'd12, SWZ_ID, 1'b0);
      step();
      check("R11 settled A", opnd_a, ea);
      begin
         logic [VW-1:0] hold_a;
         hold_a = ea;
         set_ops(2'd1, 4'd8, 8'h00, 1'b1, 2'd0, 4'd0, SWZ_ID, 1'b0, 2'd2, 4'd1, SWZ_ID, 1'b0);
         #1;
         check("R11 hold before edge", opnd_a, hold_a);
         step();
         check("R11 new after edge", opnd_a, ea);
      end

      // R12: same-cycle write and read of temporary 3
      set_ops(2'd1, 4'd3, SWZ_ID, 1'b0, 2'd1, 4'd12, SWZ_ID, 1'b0, 2'd1, 4'd13, SWZ_ID, 1'b0);
      tmp_wr_en = 1'b1; tmp_wr_idx = 4'd3; tmp_wr_vec = mkvec(8'h55, 8'h03);
      step();
      check("R12 old value on write cycle", opnd_a, ea);
      tmp_wr_en = 1'b0;
      tmod[3] = mkvec(8'h55, 8'h03);
      set_ops(2'd1, 4'd3, SWZ_ID, 1'b0, 2'd1, 4'd12, SWZ_ID, 1'b0, 2'd1, 4'd13, SWZ_ID, 1'b0);
      step();
      check("R12 new value after write", opnd_a, ea);
      check("R12 alias unaffected by writes", opnd_b, pos_vec);
      check("R12 hole unaffected by writes", opnd_c, '0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule